// File: doc/BRIEF.md
# Parallel Video Descrambler with NRZI Decode

This block sits behind a serial-video deserializer that delivers one 10-bit character per clock (27 M characters per second for a 270 Mb/s link). Each character passes through a self-synchronizing descrambler for the polynomial x^9 + x^4 + 1 and then an NRZI-to-NRZ decoder. Both stages are unrolled so that all ten bits are handled in one clock. Bit 0 of every character is the earliest bit on the serial line. The bit history that the two stages need is carried from one character to the next.

Two plain control pins choose the path. A bypass pin sends the character around both decode stages unchanged. An active-low DVB-mode pin also sends characters through unchanged, and it takes precedence over bypass. Both pins are captured in the input register together with the character they apply to. Characters travel as a stream qualified by a valid bit. The source is a free-running deserializer that cannot pause, so there is no ready signal and no back-pressure. Each valid character leaves exactly two clock edges after it enters, and a cycle without valid moves nothing.

Top module: `sdv_descrambler`

## Requirements
- R1: A character presented with in_valid high at clock edge k appears on out_data, with out_valid high, after clock edge k+1.
- R2: A clock edge with in_valid low drives out_valid low, leaves out_data at its last value and leaves the descrambler and NRZI history unchanged.
- R3: In decode mode, with r the received serial stream and bit 0 of each character the earliest, the descrambled bit is d[t] = r[t] ^ r[t-4] ^ r[t-9]. The nine most recent received bits are kept across characters.
- R4: In decode mode, out bit n[t] = d[t] ^ d[t-1], where d[t-1] for bit 0 is bit 9 of the previous descrambled character.
- R5: With bypass high and dvb_mode_n high, the character leaves unchanged, with the same latency as in decode mode.
- R6: With dvb_mode_n low, the character leaves unchanged whatever the level of bypass.
- R7: The descrambler and NRZI history advance on every valid character in every mode, so the first decoded character after a raw one uses the raw characters as history.
- R8: A clock edge with rst high clears the history, the input register and the output register. After that edge out_data is 0 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | in_data holds a character this cycle |
| in_data | input | 10 | Received character, bit 0 earliest on the line |
| bypass | input | 1 | High: skip descramble and NRZI decode |
| dvb_mode_n | input | 1 | Low: DVB pass-through, overrides bypass |
| out_valid | output | 1 | out_data holds a new character |
| out_data | output | 10 | Registered decoded or raw character |

## Verification
The assertions assume that rst is held high from time zero through at least one clock edge. They also assume that in_valid, bypass and dvb_mode_n are never unknown while rst is low, and that in_valid stays low while rst is high. The bench drives every input only on the falling edge, keeps in_valid low through every reset, and always gives the mode pins a defined level even in idle cycles. Expected decode values come from hand-worked characters and from a bit-serial model. Mode switches are arranged so that each decoded character directly follows a raw or idle one.

// File: rtl/sdv_pkg.sv
package sdv_pkg;
  localparam int unsigned CHAR_W   = 10;
  localparam int unsigned TAP_NEAR = 4;
  localparam int unsigned TAP_FAR  = 9;

  typedef enum logic {
    PATH_DECODE = 1'b0,
    PATH_RAW    = 1'b1
  } path_e;
endpackage

// File: rtl/sdv_in_stage.sv
module sdv_in_stage
  import sdv_pkg::*;
#(
  parameter int unsigned W = CHAR_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         bypass,
  input  logic         dvb_mode_n,
  output logic         q_valid,
  output logic [W-1:0] q_data,
  output path_e        q_path
);

  path_e path_sel;

  // DVB mode wins over bypass; either one selects the raw path
  always_comb begin
    if (!dvb_mode_n)  path_sel = PATH_RAW;
    else if (bypass)  path_sel = PATH_RAW;
    else              path_sel = PATH_DECODE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_data  <= '0;
      q_path  <= PATH_DECODE;
    end else begin
      q_valid <= in_valid;
      if (in_valid) begin
        q_data <= in_data;
        q_path <= path_sel;
      end
    end
  end

  AST_DVB_OVERRIDES: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dvb_mode_n) |=> (q_path == PATH_RAW)); // R6
  AST_BYPASS_SELECTS_RAW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && bypass) |=> (q_path == PATH_RAW)); // R5

endmodule

// File: rtl/sdv_descram.sv
module sdv_descram
  import sdv_pkg::*;
#(
  parameter int unsigned W        = CHAR_W,
  parameter int unsigned NEAR_TAP = TAP_NEAR,
  parameter int unsigned FAR_TAP  = TAP_FAR
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic [W-1:0] rx,
  output logic [W-1:0] dsc
);

  localparam int unsigned HIST_W = FAR_TAP;
  localparam int unsigned EXT_W  = W + HIST_W;

  // hist[HIST_W-1] is the most recent received bit, hist[0] the oldest
  logic [HIST_W-1:0] hist;
  logic [EXT_W-1:0]  ext;

  assign ext = {rx, hist};

  // Serial chain unrolled: bit i of the character sits at ext[HIST_W+i]
  for (genvar i = 0; i < W; i++) begin : g_tap
    assign dsc[i] = ext[HIST_W+i] ^ ext[HIST_W+i-NEAR_TAP] ^ ext[HIST_W+i-FAR_TAP];
  end

  always_ff @(posedge clk) begin
    if (rst)      hist <= '0;
    else if (adv) hist <= ext[EXT_W-1 -: HIST_W];
  end

  AST_ZERO_STAYS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (hist == '0 && rx == '0) |-> (dsc == '0)); // R3
  AST_HIST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(hist)); // R2

endmodule

// File: rtl/sdv_nrzi.sv
module sdv_nrzi
  import sdv_pkg::*;
#(
  parameter int unsigned W = CHAR_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic [W-1:0] dsc,
  output logic [W-1:0] nrz
);

  logic       prev;
  logic [W:0] chain;

  assign chain[0] = prev;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign chain[i+1] = dsc[i];
    assign nrz[i]     = dsc[i] ^ chain[i];
  end

  always_ff @(posedge clk) begin
    if (rst)      prev <= 1'b0;
    else if (adv) prev <= dsc[W-1];
  end

  AST_FLAT_LEVEL_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (dsc == {W{prev}}) |-> (nrz == '0)); // R4
  AST_PREV_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(prev)); // R2

endmodule

// File: rtl/sdv_out_stage.sv
module sdv_out_stage
  import sdv_pkg::*;
#(
  parameter int unsigned W = CHAR_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         q_valid,
  input  path_e        q_path,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] dec,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  logic [W-1:0] sel;

  assign sel = (q_path == PATH_RAW) ? raw : dec;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= q_valid;
      if (q_valid) out_data <= sel;
    end
  end

  AST_OUT_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !q_valid |=> (!out_valid && $stable(out_data))); // R2
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_data == '0 && !out_valid)); // R8

endmodule

// File: rtl/sdv_descrambler.sv
module sdv_descrambler
  import sdv_pkg::*;
#(
  parameter int unsigned W        = CHAR_W,
  parameter int unsigned NEAR_TAP = TAP_NEAR,
  parameter int unsigned FAR_TAP  = TAP_FAR
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         bypass,
  input  logic         dvb_mode_n,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  logic         q_valid;
  logic [W-1:0] q_data;
  path_e        q_path;
  logic [W-1:0] dsc;
  logic [W-1:0] nrz;

  sdv_in_stage #(.W(W)) u_in (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .bypass    (bypass),
    .dvb_mode_n(dvb_mode_n),
    .q_valid   (q_valid),
    .q_data    (q_data),
    .q_path    (q_path)
  );

  // History advances on every valid character, whatever the path
  sdv_descram #(.W(W), .NEAR_TAP(NEAR_TAP), .FAR_TAP(FAR_TAP)) u_dsc (
    .clk(clk),
    .rst(rst),
    .adv(q_valid),
    .rx (q_data),
    .dsc(dsc)
  );

  sdv_nrzi #(.W(W)) u_nrzi (
    .clk(clk),
    .rst(rst),
    .adv(q_valid),
    .dsc(dsc),
    .nrz(nrz)
  );

  sdv_out_stage #(.W(W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .q_valid  (q_valid),
    .q_path   (q_path),
    .raw      (q_data),
    .dec      (nrz),
    .out_valid(out_valid),
    .out_data (out_data)
  );

  AST_OUT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2)); // R1
  AST_RAW_PASS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_valid && (bypass || !dvb_mode_n), 2))
      |-> (out_data == $past(in_data, 2))); // R5

endmodule

// File: tb/test_sdv_descrambler.sv
`timescale 1ns/1ps
module test_sdv_descrambler;

  localparam int W     = 10;
  localparam int NVEC  = 10;
  localparam int NSTRM = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         bypass = 1'b0;
  logic         dvb_mode_n = 1'b1;
  logic         out_valid;
  logic [W-1:0] out_data;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sdv_descrambler i_sdv_descrambler (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .bypass(bypass), .dvb_mode_n(dvb_mode_n),
    .out_valid(out_valid), .out_data(out_data)
  );

  // {valid, bypass, dvb_mode_n, din[9:0], exp_valid, exp[9:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b1, 10'h001, 1'b1, 10'h233},  // R3 R4 decode after reset
    {1'b1, 1'b0, 1'b1, 10'h000, 1'b1, 10'h001},  // R4 carry of last bit
    {1'b1, 1'b1, 1'b1, 10'h3FF, 1'b1, 10'h3FF},  // R5 bypass
    {1'b0, 1'b0, 1'b1, 10'h000, 1'b0, 10'h3FF},  // R2 idle holds
    {1'b1, 1'b0, 1'b1, 10'h000, 1'b1, 10'h211},  // R7 history from bypass
    {1'b1, 1'b0, 1'b0, 10'h2AA, 1'b1, 10'h2AA},  // R6 DVB pass
    {1'b1, 1'b0, 1'b1, 10'h000, 1'b1, 10'h3E1},  // R7 history from DVB
    {1'b1, 1'b0, 1'b1, 10'h200, 1'b1, 10'h200},  // R3 R4
    {1'b1, 1'b0, 1'b1, 10'h000, 1'b1, 10'h319},  // R3 taps across chars
    {1'b1, 1'b1, 1'b0, 10'h155, 1'b1, 10'h155}   // R6 DVB over bypass
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic bp, input logic dn, input logic [W-1:0] d);
    in_valid = v; bypass = bp; dvb_mode_n = dn; in_data = d;
  endtask

  // Bit-serial reference: sh[k] holds the bit received k+1 bits ago
  logic [8:0] sh;
  logic       mprev;
  function automatic logic [W-1:0] ref_char(input logic [W-1:0] c);
    logic [W-1:0] o;
    for (int b = 0; b < W; b++) begin
      logic r, d;
      r     = c[b];
      d     = r ^ sh[3] ^ sh[8];
      sh    = {sh[7:0], r};
      o[b]  = d ^ mprev;
      mprev = d;
    end
    return o;
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] expq [NSTRM];
    logic [W-1:0] s;
    repeat (3) @(negedge clk);
    check("R8 reset out_data", out_data, '0);
    check("R8 reset out_valid", {9'd0, out_valid}, 10'd0);
    rst = 1'b0;

    // Table walk: row j driven at step j, checked at step j+2 (R1 latency)
    for (int j = 0; j < NVEC + 2; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        check("R1 table valid", {9'd0, out_valid}, {9'd0, VEC[j-2][10]});
        check("table data R1-row", out_data, VEC[j-2][9:0]);
      end
      if (j < NVEC) drive(VEC[j][23], VEC[j][22], VEC[j][21], VEC[j][20:11]);
      else          drive(1'b0, 1'b0, 1'b1, '0);
    end

    // R8: reset with non-zero history, then a known character
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R8 mid reset out_data", out_data, '0);
    check("R8 mid reset out_valid", {9'd0, out_valid}, 10'd0);
    rst = 1'b0;
    drive(1'b1, 1'b0, 1'b1, 10'h001);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b1, '0);
    @(negedge clk);
    check("R8 history cleared", out_data, 10'h233);

    // Streamed decode against the serial reference, R3 and R4
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    sh = '0; mprev = 1'b0; s = 10'h2B7;
    for (int j = 0; j < NSTRM + 2; j++) begin
      @(negedge clk);
      if (j >= 2) check("R3 R4 stream", out_data, expq[j-2]);
      if (j < NSTRM) begin
        s = {s[8:0], s[9] ^ s[6]} ^ 10'(j * 37);
        expq[j] = ref_char(s);
        drive(1'b1, 1'b0, 1'b1, s);
      end else drive(1'b0, 1'b0, 1'b1, '0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule